// File: doc/BRIEF.md
# Triple-Buffer Frame Slot Manager

This block decides which of three frame-buffer slots a video capture engine writes and which one a playback engine reads. It works only from frame-level strobes. The capture side reports a frame start, a frame done and an error strobe. The playback side reports a request for its next frame, a frame done and an error strobe. From these, the manager keeps a short history of completed frames. It gives the writer a slot that neither the reader nor the newest frame occupies. It chooses the reader's slot under the genlock, frame-lag and freeze (park) rules.

Event counters record three kinds of trouble:
- a reader that had to repeat a frame (underrun);
- a writer that discarded an unread frame (overwrite);
- a genlocked reader that fell behind (sync loss).

Sticky fault flags and a single interrupt pulse line complete the status. All outputs are registered. A strobe presented in one cycle is reflected on the outputs after the next rising clock edge.

Top module: `frame_slot_mgr`

## Requirements
- R1: After synchronous reset every slot is empty. newest_valid, rd_valid, wr_fault, rd_fault and irq are 0, wr_slot and rd_slot are 0, and all three counters are 0.
- R2: On cap_start, wr_slot becomes the lowest-numbered slot (0..2) that is neither the slot the reader holds after that same cycle nor the newest completed slot.
- R3: A cap_done that ends a frame with no cap_err during it (including the done cycle) publishes the write slot. newest_slot takes that value and newest_valid goes to 1.
- R4: A capture frame that saw cap_err is not published, and newest_slot is unchanged. Its cap_done sets the sticky wr_fault. A play_err strobe sets the sticky rd_fault.
- R5: If cap_start allocates a slot that holds a completed frame the reader never started, the overwrite counter increments.
- R6: Outside park and underrun, play_start selects the frame published d frames before the newest, where d = frame_delay and the value 3 means 2. If that frame's slot has since been reallocated to the writer, the newest frame is selected instead.
- R7: With genlock_en = 1, a play_start that finds no frame published since the reader's last take (or none at all) keeps rd_slot unchanged and increments the underrun counter.
- R8: With genlock_en = 1, a publication that happens while the previous published frame is still untaken increments the sync-loss counter.
- R9: With park_en = 1, play_start sets rd_slot to park_slot (0..2) regardless of genlock and frame_delay, and counts no underrun. A park_slot of 3 leaves rd_slot unchanged.
- R10: Each counter is CNT_W bits wide (4 by default), stops at all-ones (15) and never wraps.
- R11: stat_clr clears all three counters and both fault flags on the next edge.
- R12: irq pulses for one cycle, the cycle after any enabled cause:
  - a publication (irq_en_cap);
  - play_done (irq_en_play);
  - a failed cap_done or play_err (irq_en_err).

  A disabled cause produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_start | input | 1 | Capture frame start strobe |
| cap_done | input | 1 | Capture frame done strobe |
| cap_err | input | 1 | Capture bus error strobe |
| play_start | input | 1 | Playback next-frame request strobe |
| play_done | input | 1 | Playback frame done strobe |
| play_err | input | 1 | Playback bus error strobe |
| genlock_en | input | 1 | Gate playback restart on new capture |
| frame_delay | input | 2 | Playback lag in frames (0..2, 3 acts as 2) |
| park_en | input | 1 | Freeze reader on park_slot |
| park_slot | input | 2 | Slot used while parked |
| irq_en_cap | input | 1 | Interrupt enable, capture done |
| irq_en_play | input | 1 | Interrupt enable, playback done |
| irq_en_err | input | 1 | Interrupt enable, errors |
| stat_clr | input | 1 | Clear counters and fault flags |
| wr_slot | output | 2 | Slot the writer fills |
| rd_slot | output | 2 | Slot the reader uses |
| rd_valid | output | 1 | rd_slot holds a selected frame |
| newest_slot | output | 2 | Slot of newest completed frame |
| newest_valid | output | 1 | A completed frame exists |
| wr_fault | output | 1 | Sticky capture fault |
| rd_fault | output | 1 | Sticky playback fault |
| cnt_underrun | output | CNT_W | Saturating underrun count |
| cnt_overwrite | output | CNT_W | Saturating overwrite count |
| cnt_syncloss | output | CNT_W | Saturating sync-loss count |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check four rules on every cycle:
- a fresh write allocation never lands on the reader's slot;
- a failed capture frame never moves the newest slot;
- counters never decrease except on clear, and clear zeroes them;
- a genlocked reader with nothing new holds its slot, and a parked reader follows park_slot.

The bench scenarios are needed for the rest:
- the exact allocation order;
- the frame-lag history, including fallback when an old frame has been reallocated;
- overwrite and sync-loss detection;
- saturation at 15;
- the interrupt enables;
- simultaneous capture start and playback request, where the writer must avoid the slot the reader moves to in that same cycle.

// File: rtl/fsm_pkg.sv
package fsm_pkg;
  localparam int NSLOT  = 3;
  localparam int SLOT_W = 2;
  localparam int NEV    = 3;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic  vld;
    slot_t idx;
  } hist_ent_t;

  typedef enum int {
    EV_UNDER = 0,
    EV_OVER  = 1,
    EV_SYNC  = 2
  } ev_e;
endpackage

// File: rtl/fsm_wr_alloc.sv
module fsm_wr_alloc
  import fsm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             done,
  input  logic             err,
  input  logic [NSLOT-1:0] excl,
  input  logic [NSLOT-1:0] unread,
  output slot_t            wr_slot,
  output logic             wr_active,
  output slot_t            alloc_slot,
  output logic             ovw_ev,
  output logic             pub_ok,
  output logic             pub_fail
);
  logic bad;

  // lowest-numbered slot not excluded
  always_comb begin
    alloc_slot = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (!excl[i]) alloc_slot = slot_t'(i);
  end

  assign ovw_ev   = start & unread[alloc_slot];
  assign pub_ok   = done & wr_active & ~bad & ~err;
  assign pub_fail = done & wr_active & (bad | err);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_slot   <= '0;
      wr_active <= 1'b0;
      bad       <= 1'b0;
    end else if (start) begin
      wr_slot   <= alloc_slot;
      wr_active <= 1'b1;
      bad       <= err;
    end else begin
      if (done) wr_active <= 1'b0;
      else if (err && wr_active) bad <= 1'b1;
    end
  end
endmodule

// File: rtl/fsm_rd_select.sv
module fsm_rd_select
  import fsm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      genlock,
  input  logic      park,
  input  slot_t     park_slot,
  input  logic [1:0] delay,
  input  hist_ent_t hist [NSLOT],
  input  logic      new_avail,
  output slot_t     rd_slot,
  output logic      rd_valid,
  output slot_t     nxt,
  output logic      nxt_vld,
  output logic      take,
  output logic      claim,
  output logic      under
);
  logic [1:0] d;
  slot_t      pick;

  always_comb begin
    d    = (delay == 2'd3) ? 2'd2 : delay;
    pick = hist[0].idx;
    if (hist[d].vld) pick = hist[d].idx;
    nxt     = rd_slot;
    nxt_vld = rd_valid;
    take    = 1'b0;
    claim   = 1'b0;
    under   = 1'b0;
    if (start) begin
      if (park) begin
        if (park_slot != 2'd3) begin
          nxt     = park_slot;
          nxt_vld = 1'b1;
          claim   = 1'b1;
        end
      end else if (!hist[0].vld) begin
        under = genlock;
      end else if (genlock && !new_avail) begin
        under = 1'b1;
      end else begin
        nxt     = pick;
        nxt_vld = 1'b1;
        take    = 1'b1;
        claim   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_slot  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_slot  <= nxt;
      rd_valid <= nxt_vld;
    end
  end

  // R7: genlocked request with nothing new repeats the slot
  p_genlock_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (start && genlock && !park && !new_avail) |=> $stable(rd_slot));

  // R9: parked request follows park_slot
  p_park_follow_r9: assert property (@(posedge clk) disable iff (rst)
    (start && park && park_slot != 2'd3) |=> (rd_slot == $past(park_slot)));
endmodule

// File: rtl/fsm_slot_hist.sv
module fsm_slot_hist
  import fsm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pub,
  input  slot_t            pub_slot,
  input  logic             alloc,
  input  slot_t            alloc_slot,
  input  logic             claim,
  input  slot_t            claim_slot,
  input  logic             take,
  input  logic             genlock,
  output hist_ent_t        hist [NSLOT],
  output logic [NSLOT-1:0] unread,
  output logic             new_avail,
  output logic             sync_ev
);
  hist_ent_t        hn [NSLOT];
  logic [NSLOT-1:0] un;

  assign sync_ev = pub & genlock & new_avail;

  always_comb begin
    hn = hist;
    un = unread;
    if (claim) un[claim_slot] = 1'b0;
    if (pub) begin
      for (int i = NSLOT - 1; i > 0; i--) hn[i] = hist[i-1];
      hn[0] = '{vld: 1'b1, idx: pub_slot};
      un[pub_slot] = 1'b1;
    end
    if (alloc) begin
      for (int i = 0; i < NSLOT; i++)
        if (hn[i].idx == alloc_slot) hn[i].vld = 1'b0;
      un[alloc_slot] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) hist[i] <= '0;
      unread    <= '0;
      new_avail <= 1'b0;
    end else begin
      hist   <= hn;
      unread <= un;
      if (pub) new_avail <= 1'b1;
      else if (take) new_avail <= 1'b0;
    end
  end
endmodule

// File: rtl/fsm_sat_ctrs.sv
module fsm_sat_ctrs #(
  parameter int N = 3,
  parameter int W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic [N-1:0]        ev,
  output logic [N-1:0][W-1:0] cnt
);
  for (genvar g = 0; g < N; g++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (rst || clr) cnt[g] <= '0;
      else if (ev[g] && cnt[g] != {W{1'b1}}) cnt[g] <= cnt[g] + 1'b1;
    end

    // R10: no wrap, only clear lowers the count
    p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
      !clr |=> (cnt[g] >= $past(cnt[g])));

    // R11: clear zeroes the counter
    p_clear_r11: assert property (@(posedge clk) disable iff (rst)
      clr |=> (cnt[g] == '0));
  end
endmodule

// File: rtl/frame_slot_mgr.sv
module frame_slot_mgr
  import fsm_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_start,
  input  logic             cap_done,
  input  logic             cap_err,
  input  logic             play_start,
  input  logic             play_done,
  input  logic             play_err,
  input  logic             genlock_en,
  input  logic [1:0]       frame_delay,
  input  logic             park_en,
  input  logic [1:0]       park_slot,
  input  logic             irq_en_cap,
  input  logic             irq_en_play,
  input  logic             irq_en_err,
  input  logic             stat_clr,
  output logic [1:0]       wr_slot,
  output logic [1:0]       rd_slot,
  output logic             rd_valid,
  output logic [1:0]       newest_slot,
  output logic             newest_valid,
  output logic             wr_fault,
  output logic             rd_fault,
  output logic [CNT_W-1:0] cnt_underrun,
  output logic [CNT_W-1:0] cnt_overwrite,
  output logic [CNT_W-1:0] cnt_syncloss,
  output logic             irq
);
  hist_ent_t            hist [NSLOT];
  logic [NSLOT-1:0]     unread, excl;
  logic                 new_avail, sync_ev;
  slot_t                rd_nxt, alloc_slot;
  logic                 rd_nxt_vld, take, claim, under;
  logic                 wr_active, ovw_ev, pub_ok, pub_fail;
  logic [NEV-1:0]       ev;
  logic [NEV-1:0][CNT_W-1:0] cnt;

  fsm_rd_select u_rd (
    .clk(clk), .rst(rst), .start(play_start), .genlock(genlock_en),
    .park(park_en), .park_slot(park_slot), .delay(frame_delay),
    .hist(hist), .new_avail(new_avail), .rd_slot(rd_slot),
    .rd_valid(rd_valid), .nxt(rd_nxt), .nxt_vld(rd_nxt_vld),
    .take(take), .claim(claim), .under(under)
  );

  always_comb begin
    for (int i = 0; i < NSLOT; i++)
      excl[i] = (rd_nxt_vld && rd_nxt == slot_t'(i)) ||
                (hist[0].vld && hist[0].idx == slot_t'(i));
  end

  fsm_wr_alloc u_wr (
    .clk(clk), .rst(rst), .start(cap_start), .done(cap_done),
    .err(cap_err), .excl(excl), .unread(unread), .wr_slot(wr_slot),
    .wr_active(wr_active), .alloc_slot(alloc_slot), .ovw_ev(ovw_ev),
    .pub_ok(pub_ok), .pub_fail(pub_fail)
  );

  fsm_slot_hist u_hist (
    .clk(clk), .rst(rst), .pub(pub_ok), .pub_slot(wr_slot),
    .alloc(cap_start), .alloc_slot(alloc_slot), .claim(claim),
    .claim_slot(rd_nxt), .take(take), .genlock(genlock_en),
    .hist(hist), .unread(unread), .new_avail(new_avail),
    .sync_ev(sync_ev)
  );

  always_comb begin
    ev           = '0;
    ev[EV_UNDER] = under;
    ev[EV_OVER]  = ovw_ev;
    ev[EV_SYNC]  = sync_ev;
  end

  fsm_sat_ctrs #(.N(NEV), .W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .clr(stat_clr), .ev(ev), .cnt(cnt)
  );

  assign cnt_underrun  = cnt[EV_UNDER];
  assign cnt_overwrite = cnt[EV_OVER];
  assign cnt_syncloss  = cnt[EV_SYNC];
  assign newest_slot   = hist[0].idx;
  assign newest_valid  = hist[0].vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_fault <= 1'b0;
      rd_fault <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (pub_fail) wr_fault <= 1'b1;
      else if (stat_clr) wr_fault <= 1'b0;
      if (play_err) rd_fault <= 1'b1;
      else if (stat_clr) rd_fault <= 1'b0;
      irq <= (irq_en_cap & pub_ok) | (irq_en_play & play_done) |
             (irq_en_err & (pub_fail | play_err));
    end
  end

  // R2: a fresh allocation never coincides with the reader's slot
  p_wr_avoids_rd_r2: assert property (@(posedge clk) disable iff (rst)
    cap_start |=> (!rd_valid || wr_slot != rd_slot));

  // R4: a frame failing at its done strobe leaves newest unchanged
  p_fail_unpublished_r4: assert property (@(posedge clk) disable iff (rst)
    (cap_done && cap_err) |=> ($stable(newest_slot) && $stable(newest_valid)));

  // R2: slot indices stay within 0..2
  p_slot_range_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_slot != 2'd3) && (rd_slot != 2'd3) && (newest_slot != 2'd3));
endmodule

// File: tb/frame_slot_mgr_tb.sv
module frame_slot_mgr_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_start = 0, cap_done = 0, cap_err = 0;
  logic play_start = 0, play_done = 0, play_err = 0;
  logic genlock_en = 0, park_en = 0;
  logic [1:0] frame_delay = 0, park_slot = 0;
  logic irq_en_cap = 1, irq_en_play = 1, irq_en_err = 1;
  logic stat_clr = 0;
  logic [1:0] wr_slot, rd_slot, newest_slot;
  logic rd_valid, newest_valid, wr_fault, rd_fault, irq;
  logic [3:0] cnt_underrun, cnt_overwrite, cnt_syncloss;

  always #10 clk = ~clk;

  frame_slot_mgr u_dut (
    .clk(clk), .rst(rst), .cap_start(cap_start), .cap_done(cap_done),
    .cap_err(cap_err), .play_start(play_start), .play_done(play_done),
    .play_err(play_err), .genlock_en(genlock_en), .frame_delay(frame_delay),
    .park_en(park_en), .park_slot(park_slot), .irq_en_cap(irq_en_cap),
    .irq_en_play(irq_en_play), .irq_en_err(irq_en_err), .stat_clr(stat_clr),
    .wr_slot(wr_slot), .rd_slot(rd_slot), .rd_valid(rd_valid),
    .newest_slot(newest_slot), .newest_valid(newest_valid),
    .wr_fault(wr_fault), .rd_fault(rd_fault), .cnt_underrun(cnt_underrun),
    .cnt_overwrite(cnt_overwrite), .cnt_syncloss(cnt_syncloss), .irq(irq)
  );

  typedef struct {
    string req;
    int    id;
    int    val;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  function automatic int observe(int id);
    case (id)
      0:  return int'(wr_slot);
      1:  return int'(rd_slot);
      2:  return int'(rd_valid);
      3:  return int'(newest_slot);
      4:  return int'(newest_valid);
      5:  return int'(cnt_underrun);
      6:  return int'(cnt_overwrite);
      7:  return int'(cnt_syncloss);
      8:  return int'(wr_fault);
      9:  return int'(rd_fault);
      default: return int'(irq);
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      int act;
      e = q.pop_front();
      act = observe(e.id);
      checks++;
      if (act !== e.val) begin
        fails++;
        $display("FAIL %s field=%0d actual=%0d expected=%0d", e.req, e.id, act, e.val);
      end
    end
  end

  task automatic expect_v(string req, int id, int val);
    q.push_back('{req: req, id: id, val: val});
  endtask

  // driver: one clock with the given strobes, outputs settle after the edge
  task automatic step(bit ws, bit wd, bit we, bit rs, bit rdn, bit re, bit cl);
    @(negedge clk);
    cap_start = ws; cap_done = wd; cap_err = we;
    play_start = rs; play_done = rdn; play_err = re; stat_clr = cl;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    // R1 reset state
    expect_v("R1", 4, 0); expect_v("R1", 2, 0); expect_v("R1", 5, 0);
    expect_v("R1", 6, 0); expect_v("R1", 7, 0); expect_v("R1", 8, 0);
    expect_v("R1", 10, 0); expect_v("R1", 0, 0);

    step(1, 0, 0, 0, 0, 0, 0); expect_v("R2 first alloc", 0, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    expect_v("R3 publish", 3, 0); expect_v("R3 valid", 4, 1);
    expect_v("R12 cap irq", 10, 1);
    step(1, 0, 0, 0, 0, 0, 0); expect_v("R2 avoid newest", 0, 1);
    step(0, 1, 0, 0, 0, 0, 0); expect_v("R3 publish", 3, 1);
    step(0, 0, 0, 1, 0, 0, 0);
    expect_v("R6 delay0", 1, 1); expect_v("R6 valid", 2, 1);
    step(1, 0, 0, 0, 0, 0, 0);
    expect_v("R2 avoid rd+newest", 0, 0); expect_v("R5 overwrite", 6, 1);
    step(0, 1, 0, 0, 0, 0, 0); expect_v("R3 publish", 3, 0);

    frame_delay = 2'd1;
    step(0, 0, 0, 1, 0, 0, 0); expect_v("R6 delay1", 1, 1);
    frame_delay = 2'd2;
    step(0, 0, 0, 1, 0, 0, 0); expect_v("R6 delay2 fallback", 1, 0);
    frame_delay = 2'd0;

    step(1, 0, 0, 0, 0, 0, 0);
    expect_v("R2 alloc", 0, 1); expect_v("R5 no overwrite", 6, 1);
    step(0, 1, 1, 0, 0, 0, 0);
    expect_v("R4 not published", 3, 0); expect_v("R4 wr_fault", 8, 1);
    expect_v("R12 err irq", 10, 1);
    idle(); expect_v("R12 pulse ends", 10, 0);

    genlock_en = 1'b1;
    step(0, 0, 0, 1, 0, 0, 0);
    expect_v("R7 hold", 1, 0); expect_v("R7 underrun", 5, 1);
    step(1, 0, 0, 0, 0, 0, 0); expect_v("R2 alloc", 0, 1);
    step(0, 1, 0, 0, 0, 0, 0); expect_v("R8 no syncloss", 7, 0);
    step(1, 0, 0, 0, 0, 0, 0); expect_v("R2 alloc", 0, 2);
    step(0, 1, 0, 0, 0, 0, 0);
    expect_v("R8 syncloss", 7, 1); expect_v("R3 publish", 3, 2);
    step(0, 0, 0, 1, 0, 0, 0);
    expect_v("R7 take new", 1, 2); expect_v("R7 no underrun", 5, 1);

    park_en = 1'b1; park_slot = 2'd1;
    step(0, 0, 0, 1, 0, 0, 0);
    expect_v("R9 park", 1, 1); expect_v("R9 no underrun", 5, 1);
    step(1, 0, 0, 0, 0, 0, 0); expect_v("R2 avoid parked", 0, 0);
    step(0, 1, 0, 0, 0, 0, 0); expect_v("R3 publish", 3, 0);
    park_slot = 2'd3;
    step(0, 0, 0, 1, 0, 0, 0); expect_v("R9 slot3 ignored", 1, 1);
    park_en = 1'b0;
    step(0, 0, 0, 1, 0, 0, 0); expect_v("R7 genlock take", 1, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 0, 0, 0);
    expect_v("R10 saturate", 5, 15); expect_v("R7 hold", 1, 0);

    step(0, 0, 0, 0, 1, 0, 0); expect_v("R12 play irq", 10, 1);
    idle(); expect_v("R12 idle", 10, 0);
    irq_en_play = 1'b0;
    step(0, 0, 0, 0, 1, 0, 0); expect_v("R12 disabled", 10, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    expect_v("R4 rd_fault", 9, 1); expect_v("R12 err irq", 10, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    expect_v("R11 clr under", 5, 0); expect_v("R11 clr over", 6, 0);
    expect_v("R11 clr sync", 7, 0); expect_v("R11 clr wf", 8, 0);
    expect_v("R11 clr rf", 9, 0);

    genlock_en = 1'b0; frame_delay = 2'd1;
    step(1, 0, 0, 1, 0, 0, 0);
    expect_v("R6 same-cycle read", 1, 2); expect_v("R2 same-cycle alloc", 0, 1);
    expect_v("R5 no overwrite", 6, 0);
    idle();

    @(negedge clk); #1;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule